// File: doc/BRIEF.md
# Multi-Light Pixel Intensity Calculator

This block works out the lit colour of a single surface point, with a separate result for each of the red, green and blue channels. The colour is an ambient base plus one contribution from each light, and the lights are taken one after another. Each contribution is a diffuse part, which depends on how closely the surface normal lines up with the direction of the light. In full mode it also has a specular part, which depends on how closely the normal lines up with the light's half-way vector, raised to a power-of-two shininess exponent. In simple mode the specular part is left out. All vectors arrive already normalised, in signed fixed point. Coefficients and intensities are unsigned fractions with 256 standing for 1.0.

Work arrives as a stream of beats, one beat for each light, on a valid/ready handshake. The first beat that is accepted while no pixel is in progress starts a pixel. On that beat the block also captures the pixel-wide fields: mode, exponent selector, coefficients, normal, ambient colour and light count. The finished colour leaves on a second valid/ready stream. A result that is held keeps its value until the consumer takes it. While that result is held with the consumer not ready, the input side signals not-ready too, so back-pressure passes from output to input with no extra storage.

Top module: `pixel_lighting_unit`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A beat accepted while idle starts a pixel and captures in_mode, in_exp, in_kd, in_ks, in_normal and in_nlights_m1 (value c means c+1 lights, 1 to 8). Exactly c+1 beats are consumed, and out_valid rises in the cycle after the last of them is accepted.
- R3: For each channel the ambient base is floor(Ka·Ia/256), with Ka and Ia taken from the first beat.
- R4: A dot product uses three signed 10-bit components per vector, component k at bits [10k+9:10k] with x lowest. With S the sum of the three raw component products, the 8-bit result is floor(S/256) clamped to 0..255. A negative S gives 0.
- R5: One light adds floor(Il·(floor(Kd·dL/256) + spec)/256) to each channel, where dL is the normal·light dot and Il is that light's channel intensity (R at bits [7:0], G at [15:8], B at [23:16]).
- R6: With in_mode = 0 (simple), spec is 0 whatever the half-way vector and exponent are.
- R7: With in_mode = 1 (full), spec = floor(Ks·P/256). P comes from a table lookup on the normal·half dot dH: it is dH squared e times, truncating each time (p ← floor(p·p/256)), so s = 2^e. The selector e is in_exp, and values above 8 act as 8.
- R8: The channel result is the sum of the ambient base and all light contributions, saturated at 255.
- R9: On the second and later beats of a pixel, the pixel-wide fields (mode, exponent, coefficients, ambient colour, normal, light count) have no effect.
- R10: While out_valid is 1 and out_ready is 0, out_rgb stays stable and in_ready is 0.
- R11: When a result is taken in the same cycle that the first beat of a one-light pixel is accepted, the new result is valid in the next cycle with no idle cycle between, so one-light pixels run at one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_mode | input | 1 | 0 ambient+diffuse, 1 adds specular (first beat) |
| in_exp | input | 4 | Shininess selector e, s = 2^e (first beat) |
| in_nlights_m1 | input | 3 | Light count minus one (first beat) |
| in_ka | input | 8 | Ambient coefficient (first beat) |
| in_kd | input | 8 | Diffuse coefficient (first beat) |
| in_ks | input | 8 | Specular coefficient (first beat) |
| in_amb_rgb | input | 24 | Ambient intensity per channel (first beat) |
| in_normal | input | 30 | Surface normal (first beat) |
| in_ldir | input | 30 | This light's direction vector |
| in_half | input | 30 | This light's half-way vector |
| in_lrgb | input | 24 | This light's intensity per channel |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_rgb | output | 24 | Lit colour, R in [7:0] |

## Verification
The block can hand a finished result to the consumer and accept the first beat of the next pixel on the same clock edge. This is the point where an input-ready that waits for the output register to empty would show up as a bubble. The bench sets out_ready high and offers one-light pixels on consecutive cycles. At every cycle it requires in_ready to be high and the fresh result to match the expected colour of the pixel whose beat was just accepted. A separate scenario holds the output unconsumed and requires both the value and the stalled input to stay put.

// File: rtl/plu_pkg.sv
package plu_pkg;
  localparam int CW         = 8;   // coefficient, intensity and dot width
  localparam int VW         = 10;  // signed vector component width
  localparam int VFRAC      = 8;   // fractional bits of a component
  localparam int MAX_LIGHTS = 8;
  localparam int NEXP       = 9;   // exponents 2^0 .. 2^8
  localparam int ESW        = 4;   // exponent selector width
  localparam int NCH        = 3;   // colour channels
  localparam int CNTW       = $clog2(MAX_LIGHTS);
endpackage

// File: rtl/plu_dot3.sv
module plu_dot3 #(
  parameter int VW    = plu_pkg::VW,
  parameter int VFRAC = plu_pkg::VFRAC,
  parameter int CW    = plu_pkg::CW
) (
  input  logic [3*VW-1:0] a_i,
  input  logic [3*VW-1:0] b_i,
  output logic [CW-1:0]   dot_o
);
  localparam int PW = 2 * VW;
  localparam int SW = PW + 2;
  localparam int SH = 2 * VFRAC - CW;

  logic signed [PW-1:0] ea [3];
  logic signed [PW-1:0] eb [3];
  logic signed [PW-1:0] pr [3];
  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] q;

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      ea[k] = {{VW{a_i[k*VW+VW-1]}}, a_i[k*VW +: VW]};
      eb[k] = {{VW{b_i[k*VW+VW-1]}}, b_i[k*VW +: VW]};
      pr[k] = ea[k] * eb[k];
    end
    sum = {{2{pr[0][PW-1]}}, pr[0]} + {{2{pr[1][PW-1]}}, pr[1]}
        + {{2{pr[2][PW-1]}}, pr[2]};
    q = sum >>> SH;
    if (sum[SW-1])           dot_o = '0;
    else if (|q[SW-1:CW])    dot_o = {CW{1'b1}};
    else                     dot_o = q[CW-1:0];
  end
endmodule

// File: rtl/plu_spec_rom.sv
module plu_spec_rom #(
  parameter int CW   = plu_pkg::CW,
  parameter int NEXP = plu_pkg::NEXP,
  parameter int ESW  = plu_pkg::ESW
) (
  input  logic [CW-1:0]  addr_i,
  input  logic [ESW-1:0] sel_i,
  output logic [CW-1:0]  pw_o
);
  localparam int DEPTH = 1 << CW;
  localparam int TBITS = DEPTH * CW;

  function automatic logic [TBITS-1:0] build_tbl(input int k);
    logic [TBITS-1:0] t;
    int p;
    t = '0;
    for (int x = 0; x < DEPTH; x++) begin
      p = x;
      for (int j = 0; j < k; j++) p = (p * p) >> CW;
      t[x*CW +: CW] = CW'(p);
    end
    return t;
  endfunction

  logic [CW-1:0] tap [NEXP];

  for (genvar k = 0; k < NEXP; k++) begin : g_tbl
    localparam logic [TBITS-1:0] TBL = build_tbl(k);
    assign tap[k] = TBL[addr_i*CW +: CW];
  end

  always_comb begin
    pw_o = tap[NEXP-1];
    for (int k = 0; k < NEXP - 1; k++)
      if (int'(sel_i) == k) pw_o = tap[k];
  end

  always_comb begin
    // R7
    if (addr_i == '0) lut_zero_chk: assert (pw_o == '0);
    // R7
    if (sel_i == '0) lut_ident_chk: assert (pw_o == addr_i);
  end
endmodule

// File: rtl/plu_light_term.sv
module plu_light_term #(
  parameter int CW = plu_pkg::CW
) (
  input  logic [CW-1:0] il_i,
  input  logic [CW-1:0] kd_i,
  input  logic [CW-1:0] ks_i,
  input  logic [CW-1:0] dl_i,
  input  logic [CW-1:0] sp_i,
  input  logic          spec_en_i,
  output logic [CW:0]   term_o
);
  localparam int PW = 2 * CW;
  localparam int QW = 2 * CW + 1;

  logic [PW-1:0] dm, sm;
  logic [CW-1:0] dpart, spart;
  logic [CW:0]   mix;
  logic [QW-1:0] qm;

  always_comb begin
    dm     = PW'(kd_i) * PW'(dl_i);
    sm     = PW'(ks_i) * PW'(sp_i);
    dpart  = dm[PW-1:CW];
    spart  = spec_en_i ? sm[PW-1:CW] : '0;
    mix    = {1'b0, dpart} + {1'b0, spart};
    qm     = QW'(il_i) * QW'(mix);
    term_o = qm[QW-1:CW];
  end
endmodule

// File: rtl/pixel_lighting_unit.sv
module pixel_lighting_unit
  import plu_pkg::*;
#(
  parameter int P_CW    = plu_pkg::CW,
  parameter int P_VW    = plu_pkg::VW,
  parameter int P_ESW   = plu_pkg::ESW,
  parameter int P_CNTW  = plu_pkg::CNTW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_mode,
  input  logic [P_ESW-1:0]      in_exp,
  input  logic [P_CNTW-1:0]     in_nlights_m1,
  input  logic [P_CW-1:0]       in_ka,
  input  logic [P_CW-1:0]       in_kd,
  input  logic [P_CW-1:0]       in_ks,
  input  logic [3*P_CW-1:0]     in_amb_rgb,
  input  logic [3*P_VW-1:0]     in_normal,
  input  logic [3*P_VW-1:0]     in_ldir,
  input  logic [3*P_VW-1:0]     in_half,
  input  logic [3*P_CW-1:0]     in_lrgb,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [3*P_CW-1:0]     out_rgb
);
  localparam int AW  = P_CW + 2 + P_CNTW;
  localparam int MW2 = 2 * P_CW;
  localparam int VEC = 3 * P_VW;

  logic                busy;
  logic [P_CNTW-1:0]   remain;
  logic                mode_q;
  logic [P_ESW-1:0]    exp_q;
  logic [P_CW-1:0]     kd_q, ks_q;
  logic [VEC-1:0]      nrm_q;
  logic [NCH*AW-1:0]   acc_q, acc_nx;
  logic [NCH*P_CW-1:0] sat_nx, out_q;

  logic                fire, last, mode_eff;
  logic [P_ESW-1:0]    exp_eff;
  logic [P_CW-1:0]     kd_eff, ks_eff, d_l, d_h, sp;
  logic [VEC-1:0]      nrm_eff;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign mode_eff = busy ? mode_q : in_mode;
  assign exp_eff  = busy ? exp_q  : in_exp;
  assign kd_eff   = busy ? kd_q   : in_kd;
  assign ks_eff   = busy ? ks_q   : in_ks;
  assign nrm_eff  = busy ? nrm_q  : in_normal;
  assign last     = busy ? (remain == '0) : (in_nlights_m1 == '0);
  assign out_rgb  = out_q;

  plu_dot3 #(.VW(P_VW), .CW(P_CW)) u_dot_l (
    .a_i(nrm_eff), .b_i(in_ldir), .dot_o(d_l));
  plu_dot3 #(.VW(P_VW), .CW(P_CW)) u_dot_h (
    .a_i(nrm_eff), .b_i(in_half), .dot_o(d_h));
  plu_spec_rom #(.CW(P_CW), .ESW(P_ESW)) u_spec (
    .addr_i(d_h), .sel_i(exp_eff), .pw_o(sp));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [MW2-1:0] amb_m;
    logic [P_CW:0]  term;
    logic [AW-1:0]  base, nx;

    assign amb_m = MW2'(in_ka) * MW2'(in_amb_rgb[c*P_CW +: P_CW]);

    plu_light_term #(.CW(P_CW)) u_term (
      .il_i(in_lrgb[c*P_CW +: P_CW]), .kd_i(kd_eff), .ks_i(ks_eff),
      .dl_i(d_l), .sp_i(sp), .spec_en_i(mode_eff), .term_o(term));

    assign base = busy ? acc_q[c*AW +: AW] : AW'(amb_m[MW2-1:P_CW]);
    assign nx   = base + AW'(term);
    assign acc_nx[c*AW +: AW]     = nx;
    assign sat_nx[c*P_CW +: P_CW] = (|nx[AW-1:P_CW]) ? {P_CW{1'b1}} : nx[P_CW-1:0];

    // R8
    acc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && busy) |=> (acc_q[c*AW +: AW] >= $past(acc_q[c*AW +: AW])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remain    <= '0;
      out_valid <= 1'b0;
      mode_q    <= 1'b0;
      exp_q     <= '0;
      kd_q      <= '0;
      ks_q      <= '0;
      nrm_q     <= '0;
      acc_q     <= '0;
      out_q     <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fire) begin
        acc_q <= acc_nx;
        if (!busy) begin
          mode_q <= in_mode;
          exp_q  <= in_exp;
          kd_q   <= in_kd;
          ks_q   <= in_ks;
          nrm_q  <= in_normal;
        end
        if (last) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_q     <= sat_nx;
        end else begin
          busy   <= 1'b1;
          remain <= busy ? (remain - P_CNTW'(1)) : (in_nlights_m1 - P_CNTW'(1));
        end
      end
    end
  end

  // independent beat tally for the checks below
  logic [P_CNTW:0] chk_beats, chk_target;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_beats  <= '0;
      chk_target <= '0;
    end else if (fire) begin
      chk_beats  <= busy ? chk_beats + (P_CNTW+1)'(1) : (P_CNTW+1)'(1);
      chk_target <= busy ? chk_target : {1'b0, in_nlights_m1} + (P_CNTW+1)'(1);
    end
  end

  // R2
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (out_valid && chk_beats == chk_target));
  // R2
  busy_idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));
  // R11
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !busy && in_nlights_m1 == '0) |=> out_valid);
endmodule

// File: tb/pixel_lighting_unit_tb_top.sv
module pixel_lighting_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic        in_mode = 1'b0;
  logic [3:0]  in_exp = '0;
  logic [2:0]  in_nlights_m1 = '0;
  logic [7:0]  in_ka = '0, in_kd = '0, in_ks = '0;
  logic [23:0] in_amb_rgb = '0, in_lrgb = '0;
  logic [29:0] in_normal = '0, in_ldir = '0, in_half = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [23:0] out_rgb;

  always #10 clk = ~clk;

  pixel_lighting_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_exp(in_exp), .in_nlights_m1(in_nlights_m1),
    .in_ka(in_ka), .in_kd(in_kd), .in_ks(in_ks), .in_amb_rgb(in_amb_rgb),
    .in_normal(in_normal), .in_ldir(in_ldir), .in_half(in_half),
    .in_lrgb(in_lrgb), .out_valid(out_valid), .out_ready(out_ready),
    .out_rgb(out_rgb));

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // pixel description used by the reference model
  int p_mode, p_exp, p_nl, p_ka, p_kd, p_ks;
  int p_amb[3], p_n[3];
  int l_dir[8][3], l_half[8][3], l_i[8][3];
  bit scramble = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dotq(input int a0, a1, a2, b0, b1, b2);
    int s = a0*b0 + a1*b1 + a2*b2;
    if (s < 0) return 0;
    s = s / 256;
    return (s > 255) ? 255 : s;
  endfunction

  function automatic int powq(input int d, input int e);
    int p = d;
    int ee = (e > 8) ? 8 : e;
    for (int j = 0; j < ee; j++) p = (p * p) / 256;
    return p;
  endfunction

  function automatic int model(input int c);
    int acc = (p_ka * p_amb[c]) / 256;
    for (int l = 0; l < p_nl; l++) begin
      int dl = dotq(p_n[0], p_n[1], p_n[2], l_dir[l][0], l_dir[l][1], l_dir[l][2]);
      int dh = dotq(p_n[0], p_n[1], p_n[2], l_half[l][0], l_half[l][1], l_half[l][2]);
      int sp = p_mode ? (p_ks * powq(dh, p_exp)) / 256 : 0;
      acc += (l_i[l][c] * ((p_kd * dl) / 256 + sp)) / 256;
    end
    return (acc > 255) ? 255 : acc;
  endfunction

  task automatic apply_beat(input int l, input bit first);
    bit alt = scramble && !first;
    in_mode       = alt ? 1'(~p_mode[0]) : 1'(p_mode);
    in_exp        = alt ? 4'(p_exp + 5) : 4'(p_exp);
    in_nlights_m1 = alt ? 3'd7 : 3'(p_nl - 1);
    in_ka         = alt ? 8'd255 : 8'(p_ka);
    in_kd         = alt ? 8'(255 - p_kd) : 8'(p_kd);
    in_ks         = alt ? 8'(255 - p_ks) : 8'(p_ks);
    in_amb_rgb    = alt ? 24'hFFFFFF : {8'(p_amb[2]), 8'(p_amb[1]), 8'(p_amb[0])};
    in_normal     = alt ? {10'd0, 10'd256, 10'd0}
                        : {10'(p_n[2]), 10'(p_n[1]), 10'(p_n[0])};
    in_ldir = {10'(l_dir[l][2]), 10'(l_dir[l][1]), 10'(l_dir[l][0])};
    in_half = {10'(l_half[l][2]), 10'(l_half[l][1]), 10'(l_half[l][0])};
    in_lrgb = {8'(l_i[l][2]), 8'(l_i[l][1]), 8'(l_i[l][0])};
  endtask

  task automatic check_rgb(input string req);
    for (int c = 0; c < 3; c++)
      chk(out_rgb[c*8 +: 8] == 8'(model(c)), req, $sformatf("ch%0d", c),
          int'(out_rgb[c*8 +: 8]), model(c));
  endtask

  // sends one pixel, checks R2 timing, then takes and checks the result
  task automatic run_pixel(input string req);
    for (int l = 0; l < p_nl; l++) begin
      apply_beat(l, l == 0);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (l < p_nl - 1)
        chk(!out_valid, "R2", "out_valid before last beat", int'(out_valid), 0);
    end
    chk(out_valid, "R2", "out_valid after last beat", int'(out_valid), 1);
    check_rgb(req);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic set_light(input int l, input int d0, d1, d2, h0, h1, h2,
                           input int ir, ig, ib);
    l_dir[l][0] = d0; l_dir[l][1] = d1; l_dir[l][2] = d2;
    l_half[l][0] = h0; l_half[l][1] = h1; l_half[l][2] = h2;
    l_i[l][0] = ir; l_i[l][1] = ig; l_i[l][2] = ib;
  endtask

  task automatic set_pix(input int mode, e, nl, ka, kd, ks, ar, ag, ab,
                         input int n0, n1, n2);
    p_mode = mode; p_exp = e; p_nl = nl; p_ka = ka; p_kd = kd; p_ks = ks;
    p_amb[0] = ar; p_amb[1] = ag; p_amb[2] = ab;
    p_n[0] = n0; p_n[1] = n1; p_n[2] = n2;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_ambient();  // R3: perpendicular light leaves ambient only
    set_pix(1, 2, 1, 200, 180, 100, 255, 128, 10, 0, 0, 256);
    set_light(0, 256, 0, 0, 0, 256, 0, 200, 200, 200);
    run_pixel("R3");
  endtask

  task automatic t_simple();  // R5 R6: aligned half vector must add nothing
    set_pix(0, 0, 2, 30, 200, 200, 40, 40, 40, 0, 0, 256);
    set_light(0, 0, 181, 181, 0, 0, 256, 200, 150, 100);
    set_light(1, 100, 0, 240, 0, 0, 256, 50, 255, 30);
    run_pixel("R6");
  endtask

  task automatic t_full();  // R7 R8: three lights with specular
    set_pix(1, 3, 3, 60, 150, 220, 90, 60, 30, 30, 147, 200);
    set_light(0, 40, 120, 200, 20, 140, 210, 255, 200, 100);
    set_light(1, -80, 60, 230, 10, 100, 230, 120, 220, 40);
    set_light(2, 200, -30, 120, 30, 120, 220, 60, 90, 250);
    run_pixel("R8");
  endtask

  task automatic t_exponents();  // R7: every selector, above-range clamps
    for (int e = 0; e < 10; e++) begin
      set_pix(1, e, 1, 0, 10, 250, 0, 0, 0, 0, 0, 256);
      set_light(0, 0, 0, 0, 0, 0, 230, 255, 255, 255);
      run_pixel($sformatf("R7_e%0d", e));
    end
  endtask

  task automatic t_negative();  // R4: opposed vectors clamp to zero
    set_pix(1, 1, 2, 100, 255, 255, 100, 150, 200, 100, 100, 100);
    set_light(0, -200, 50, 50, -100, -100, 20, 255, 255, 255);
    set_light(1, -256, -10, 0, 0, -100, -200, 255, 255, 255);
    run_pixel("R4");
  endtask

  task automatic t_saturate();  // R8 and R2 at eight lights
    set_pix(1, 0, 8, 255, 255, 255, 255, 255, 255, 0, 0, 256);
    for (int l = 0; l < 8; l++) set_light(l, 0, 0, 256, 0, 0, 256, 255, 255, 255);
    run_pixel("R8_sat");
  endtask

  task automatic t_ignored();  // R9: later beats carry conflicting pixel fields
    set_pix(1, 2, 2, 80, 120, 180, 100, 50, 200, 0, 100, 230);
    set_light(0, 0, 90, 230, 0, 60, 240, 180, 100, 220);
    set_light(1, 50, 50, 230, 10, 80, 230, 90, 200, 60);
    scramble = 1;
    run_pixel("R9");
    scramble = 0;
  endtask

  task automatic t_backpressure();  // R10
    logic [23:0] held;
    set_pix(1, 4, 1, 50, 200, 200, 100, 100, 100, 0, 0, 256);
    set_light(0, 0, 100, 220, 0, 30, 250, 240, 120, 60);
    apply_beat(0, 1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    held = out_rgb;
    check_rgb("R10");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(out_valid && out_rgb == held, "R10", "held result", int'(out_rgb), int'(held));
      chk(!in_ready, "R10", "in_ready while held", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid, "R10", "out_valid after take", int'(out_valid), 0);
  endtask

  task automatic t_back_to_back();  // R11
    int exp_c[4][3];
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      set_pix(k % 2, k, 1, 40 * k + 20, 100 + 30 * k, 150, 200, 100, 50, 0, 60 * k, 240);
      set_light(0, 20 * k, 80, 220, 0, 50, 240, 100 + 40 * k, 200, 60);
      for (int c = 0; c < 3; c++) exp_c[k][c] = model(c);
      if (k == 0) begin
        apply_beat(0, 1);
        in_valid = 1'b1;
      end
      @(negedge clk);
      chk(out_valid, "R11", "out_valid each cycle", int'(out_valid), 1);
      for (int c = 0; c < 3; c++)
        chk(out_rgb[c*8 +: 8] == 8'(exp_c[k][c]), "R11", $sformatf("pix%0d ch%0d", k, c),
            int'(out_rgb[c*8 +: 8]), exp_c[k][c]);
      chk(in_ready, "R11", "in_ready while taking", int'(in_ready), 1);
      if (k < 3) begin
        set_pix((k + 1) % 2, k + 1, 1, 40 * (k + 1) + 20, 100 + 30 * (k + 1), 150,
                200, 100, 50, 0, 60 * (k + 1), 240);
        set_light(0, 20 * (k + 1), 80, 220, 0, 50, 240, 100 + 40 * (k + 1), 200, 60);
        apply_beat(0, 1);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(!out_valid, "R11", "drained", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ambient();
    t_simple();
    t_full();
    t_exponents();
    t_negative();
    t_saturate();
    t_ignored();
    t_backpressure();
    t_back_to_back();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule